// File: doc/BRIEF.md
# Interrupt-Driven Key Matrix Scanner

This block serves a 6-by-6 key matrix whose column lines are pulled high outside the chip. While nothing is pressed, every row output is held low, so any key pulls its column low and the block wakes up. There is no periodic polling while idle. A press must persist through a debounce window. After that the block raises a one-cycle interrupt and starts scanning. In each scan pass it drives one row low at a time, holding each row for a fixed pulse width, and keeps all rows high for the rest of the pass period. At the end of each row's pulse it samples the synchronised columns.

A key is reported as a 6-bit code, row times six plus column, together with a one-cycle valid strobe. The strobe fires once the same key has been found in two consecutive passes. It fires once per press. The first pass that finds no key emits a one-cycle release strobe and returns the matrix to the idle, all-rows-low state. A separate power key is synchronised and edge-detected, and each press toggles a persistent on/off flag.

Top module: `key_matrix_scanner`

## Requirements
- R1: After reset, row_n_o is all zeros, irq_o, key_valid_o and key_release_o are 0, key_code_o is 0 and power_on_o is 0.
- R2: While idle (no scan in progress), all six row outputs are driven low (row_n_o = 6'b000000).
- R3: During a scan pass, rows 0 to 5 are driven low one at a time in ascending order, each for PULSE_CYC cycles, and only the active row is low (row r active means row_n_o = ~(1<<r)). All rows are then high for PERIOD_CYC - 6*PULSE_CYC cycles. The pass then repeats.
- R4: A column low in idle must persist for DEB_CYC consecutive synchronised cycles before a scan starts. A shorter pulse causes no interrupt and leaves the rows low.
- R5: irq_o is a one-cycle pulse that rises DEB_CYC+3 clock edges after a column falls in idle. Row 0 becomes active on that same edge.
- R6: key_code_o = row*6 + column. key_valid_o pulses for one cycle at the end of the second consecutive pass that finds the same key, DEB_CYC+3+PERIOD_CYC+6*PULSE_CYC edges after the column falls. It does not pulse again while the key stays held.
- R7: With several keys down, the reported key is the one in the lowest-numbered row, and within that row the lowest-numbered column.
- R8: The first pass that finds no key ends with a one-cycle key_release_o pulse. On that cycle all rows are low again (idle). key_release_o and key_valid_o never pulse together.
- R9: Each rising edge of pwr_key_i toggles power_on_o exactly once, 3 clock edges after the input rises. Holding the key causes no further toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_n_i | input | 6 | Column lines, low when a key on an active row is pressed |
| pwr_key_i | input | 1 | Power key, high while pressed |
| row_n_o | output | 6 | Row drives, low = active |
| irq_o | output | 1 | One-cycle wake-up interrupt |
| key_code_o | output | 6 | Last reported key code |
| key_valid_o | output | 1 | One-cycle strobe for a newly confirmed key |
| key_release_o | output | 1 | One-cycle strobe when no key is found in a pass |
| power_on_o | output | 1 | Persistent on/off flag |

## Verification
Every result is due a fixed number of edges after the stimulus edge. The interrupt and the first row pulse come DEB_CYC+3 edges after a column falls. The valid strobe and its code come one period plus six row pulses after that. The power flag flips three edges after its input rises. The bench changes inputs at a falling edge and then counts rising edges. It samples at the following falling edge, so each check reads exactly the cycle where the result is due, and it also checks the cycle just before. Release timing depends on where in a pass the key is let go, so the bench waits for the strobe within a two-period bound and checks the rows in the same sample.

// File: rtl/kms_pkg.sv
package kms_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEB   = 2'd1,
        ST_PULSE = 2'd2,
        ST_GAP   = 2'd3
    } scan_st_e;
endpackage

// File: rtl/kms_sync.sv
module kms_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= {W{RST_VAL}};
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kms_power.sv
module kms_power (
    input  logic clk,
    input  logic rst_n,
    input  logic key_s_i,
    output logic power_on_o
);
    typedef struct packed {
        logic prev;
        logic on;
    } pwr_t;

    pwr_t pwr_d, pwr_q;

    always_comb begin
        pwr_d      = pwr_q;
        pwr_d.prev = key_s_i;
        if (key_s_i && !pwr_q.prev) pwr_d.on = ~pwr_q.on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_q <= '0;
        else        pwr_q <= pwr_d;
    end

    assign power_on_o = pwr_q.on;

    // R9: a fresh edge flips the flag on the next edge
    p_power_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (key_s_i && !pwr_q.prev) |=> (power_on_o != $past(power_on_o)));
    // R9: without a fresh edge the flag holds
    p_power_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_s_i && !pwr_q.prev) |=> $stable(power_on_o));
endmodule

// File: rtl/kms_scan.sv
module kms_scan
    import kms_pkg::*;
#(
    parameter int ROWS       = 6,
    parameter int COLS       = 6,
    parameter int PULSE_CYC  = 100000,
    parameter int PERIOD_CYC = 10000000,
    parameter int DEB_CYC    = 200000
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [COLS-1:0]                      col_s_i,
    output logic [ROWS-1:0]                      row_n_o,
    output logic                                 irq_o,
    output logic [$clog2(ROWS*COLS)-1:0]         code_o,
    output logic                                 valid_o,
    output logic                                 release_o
);
    localparam int CODE_W  = $clog2(ROWS*COLS);
    localparam int ROW_W   = $clog2(ROWS);
    localparam int COL_W   = $clog2(COLS);
    localparam int GAP_CYC = PERIOD_CYC - ROWS*PULSE_CYC;
    localparam int MAX_A   = (PULSE_CYC > DEB_CYC) ? PULSE_CYC : DEB_CYC;
    localparam int MAX_CNT = (GAP_CYC > MAX_A) ? GAP_CYC : MAX_A;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef struct packed {
        scan_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  row;
        logic              found;
        logic [CODE_W-1:0] hit_code;
        logic              prev_ok;
        logic [CODE_W-1:0] prev_code;
        logic              reported;
        logic [CODE_W-1:0] code;
        logic              valid;
        logic              rel;
        logic              irq;
    } scan_t;

    scan_t s_d, s_q;

    logic              any_low;
    logic [COL_W-1:0]  first_col;
    logic              hit_now;
    logic [CODE_W-1:0] code_now;
    logic              same_key;

    always_comb begin
        any_low   = ~&col_s_i;
        first_col = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (!col_s_i[c]) first_col = COL_W'(c);
        end
        hit_now  = s_q.found | any_low;
        code_now = s_q.found ? s_q.hit_code
                             : CODE_W'(s_q.row) * CODE_W'(COLS) + CODE_W'(first_col);
        same_key = s_q.prev_ok && (s_q.prev_code == code_now);
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.rel   = 1'b0;
        s_d.irq   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (any_low) begin
                    s_d.st  = ST_DEB;
                    s_d.cnt = '0;
                end
            end
            ST_DEB: begin
                if (!any_low) begin
                    s_d.st = ST_IDLE;
                end else if (s_q.cnt == CNT_W'(DEB_CYC - 1)) begin
                    s_d.st       = ST_PULSE;
                    s_d.cnt      = '0;
                    s_d.row      = '0;
                    s_d.irq      = 1'b1;
                    s_d.found    = 1'b0;
                    s_d.prev_ok  = 1'b0;
                    s_d.reported = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_PULSE: begin
                if (s_q.cnt == CNT_W'(PULSE_CYC - 1)) begin
                    s_d.cnt = '0;
                    if (s_q.row == ROW_W'(ROWS - 1)) begin
                        s_d.found = 1'b0;
                        if (hit_now) begin
                            if (same_key && !s_q.reported) begin
                                s_d.valid    = 1'b1;
                                s_d.code     = code_now;
                                s_d.reported = 1'b1;
                            end else if (!same_key) begin
                                s_d.reported = 1'b0;
                            end
                            s_d.prev_ok   = 1'b1;
                            s_d.prev_code = code_now;
                            s_d.st        = ST_GAP;
                        end else begin
                            s_d.rel = 1'b1;
                            s_d.st  = ST_IDLE;
                        end
                    end else begin
                        s_d.row      = s_q.row + 1'b1;
                        s_d.found    = hit_now;
                        s_d.hit_code = code_now;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (s_q.cnt == CNT_W'(GAP_CYC - 1)) begin
                    s_d.st  = ST_PULSE;
                    s_d.cnt = '0;
                    s_d.row = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (s_q.st)
            ST_PULSE: row_n_o = ~(ROWS'(1) << s_q.row);
            ST_GAP:   row_n_o = '1;
            default:  row_n_o = '0;
        endcase
    end

    assign irq_o     = s_q.irq;
    assign code_o    = s_q.code;
    assign valid_o   = s_q.valid;
    assign release_o = s_q.rel;

    // R3: never more than one row active unless all are (idle)
    p_rows_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~row_n_o) <= 1) || (row_n_o == '0));
    // R5: interrupt lasts one cycle and lands on the first row
    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (row_n_o == ~ROWS'(1)) ##1 !irq_o);
    // R6: reported code lies inside the matrix
    p_valid_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (code_o < CODE_W'(ROWS*COLS)));
    // R8: release never coincides with a report and returns rows low
    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> (!valid_o && (row_n_o == '0)));
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner #(
    parameter int ROWS        = 6,
    parameter int COLS        = 6,
    parameter int PULSE_CYC   = 100000,
    parameter int PERIOD_CYC  = 10000000,
    parameter int DEB_CYC     = 200000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [COLS-1:0]              col_n_i,
    input  logic                         pwr_key_i,
    output logic [ROWS-1:0]              row_n_o,
    output logic                         irq_o,
    output logic [$clog2(ROWS*COLS)-1:0] key_code_o,
    output logic                         key_valid_o,
    output logic                         key_release_o,
    output logic                         power_on_o
);
    logic [COLS-1:0] col_s;
    logic            pwr_s;

    kms_sync #(.W(COLS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_col_sync (
        .clk(clk), .rst_n(rst_n), .d_i(col_n_i), .q_o(col_s)
    );

    kms_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pwr_key_i), .q_o(pwr_s)
    );

    kms_power u_power (
        .clk(clk), .rst_n(rst_n), .key_s_i(pwr_s), .power_on_o(power_on_o)
    );

    kms_scan #(
        .ROWS(ROWS), .COLS(COLS), .PULSE_CYC(PULSE_CYC),
        .PERIOD_CYC(PERIOD_CYC), .DEB_CYC(DEB_CYC)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .col_s_i(col_s),
        .row_n_o(row_n_o), .irq_o(irq_o), .code_o(key_code_o),
        .valid_o(key_valid_o), .release_o(key_release_o)
    );
endmodule

// File: tb/tb_key_matrix_scanner.sv
`timescale 1ns/1ps
module tb_key_matrix_scanner;
    localparam int ROWS = 6, COLS = 6;
    localparam int PULSE = 4, PERIOD = 40, DEB = 3;
    localparam int IRQ_K = DEB + 3;
    localparam int VAL_K = IRQ_K + PERIOD + ROWS*PULSE;
    localparam int NVEC = 5;
    // each entry: {row[2:0], col[2:0]}
    localparam logic [5:0] VEC [NVEC] = '{6'o00, 6'o55, 6'o23, 6'o41, 6'o15};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [COLS-1:0] col_n;
    logic pwr_key = 1'b0;
    logic [ROWS-1:0] row_n;
    logic irq, key_valid, key_release, power_on;
    logic [5:0] key_code;
    logic [ROWS*COLS-1:0] pressed = '0;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // matrix model: a pressed key shorts its column to its row
    always_comb begin
        col_n = '1;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (pressed[r*COLS+c] && !row_n[r]) col_n[c] = 1'b0;
    end

    key_matrix_scanner #(.PULSE_CYC(PULSE), .PERIOD_CYC(PERIOD), .DEB_CYC(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .col_n_i(col_n), .pwr_key_i(pwr_key),
        .row_n_o(row_n), .irq_o(irq), .key_code_o(key_code),
        .key_valid_o(key_valid), .key_release_o(key_release), .power_on_o(power_on)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_release(input string req);
        bit got = 0;
        for (int i = 0; i < 2*PERIOD + 10; i++) begin
            step();
            if (key_release) begin
                got = 1;
                break;
            end
        end
        check({req, " release strobe"}, got, 1);
        check({req, " rows low at release"}, row_n, 0);
    endtask

    task automatic wait_code(input string req, input int exp);
        bit got = 0;
        for (int i = 0; i < VAL_K + 10; i++) begin
            step();
            if (key_valid) begin
                got = 1;
                break;
            end
        end
        check({req, " valid seen"}, got, 1);
        check({req, " code"}, key_code, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        check("R1 rows", row_n, 0);
        check("R1 irq", irq, 0);
        check("R1 valid", key_valid, 0);
        check("R1 release", key_release, 0);
        check("R1 code", key_code, 0);
        check("R1 power", power_on, 0);
        rst_n = 1'b1;
        repeat (3) step();
        check("R2 idle rows low", row_n, 0);

        // table walk: single keys, R3 R5 R6 R8
        for (int v = 0; v < NVEC; v++) begin
            int r, c, nval;
            r = int'(VEC[v][5:3]);
            c = int'(VEC[v][2:0]);
            pressed[r*COLS+c] = 1'b1;
            nval = 0;
            for (int k = 1; k <= VAL_K; k++) begin
                step();
                if (k == IRQ_K - 1) check("R5 irq not early", irq, 0);
                if (k == IRQ_K) begin
                    check("R5 irq due", irq, 1);
                    check("R3 row0 active", row_n, 6'b111110);
                end
                if (k == IRQ_K + 1) check("R5 irq one cycle", irq, 0);
                if (k == IRQ_K + 2*PULSE) check("R3 row2 active", row_n, 6'b111011);
                if (k == IRQ_K + ROWS*PULSE) check("R3 gap rows high", row_n, 6'b111111);
                if (k == IRQ_K + PERIOD) check("R3 next pass row0", row_n, 6'b111110);
                if (k < VAL_K && key_valid) nval++;
            end
            check("R6 no early valid", nval, 0);
            check("R6 valid due", key_valid, 1);
            check("R6 code", key_code, r*COLS + c);
            nval = 0;
            for (int k = 0; k < 2*PERIOD; k++) begin
                step();
                if (key_valid) nval++;
            end
            check("R6 single report while held", nval, 0);
            pressed = '0;
            wait_release("R8");
            repeat (10) step();
        end

        // R4 short glitch is ignored
        begin
            int nirq = 0;
            pressed[2*COLS+2] = 1'b1;
            step();
            step();
            pressed = '0;
            for (int k = 0; k < 20; k++) begin
                step();
                if (irq) nirq++;
            end
            check("R4 glitch no irq", nirq, 0);
            check("R4 rows still low", row_n, 0);
        end

        // R7 priority: lowest row wins
        pressed[1*COLS+4] = 1'b1;
        pressed[3*COLS+0] = 1'b1;
        wait_code("R7 lowest row", 1*COLS + 4);
        pressed = '0;
        wait_release("R7");
        repeat (10) step();
        // R7 priority: lowest column within a row
        pressed[2*COLS+3] = 1'b1;
        pressed[2*COLS+1] = 1'b1;
        wait_code("R7 lowest column", 2*COLS + 1);
        pressed = '0;
        wait_release("R7");
        repeat (10) step();

        // R9 power key toggle
        pwr_key = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            step();
            if (k == 2) check("R9 not yet toggled", power_on, 0);
            if (k == 3) check("R9 toggled on", power_on, 1);
            if (k == 10) check("R9 hold no retoggle", power_on, 1);
        end
        pwr_key = 1'b0;
        repeat (5) step();
        pwr_key = 1'b1;
        repeat (3) step();
        check("R9 toggled off", power_on, 0);
        pwr_key = 1'b0;
        repeat (5) step();
        check("R9 stays off", power_on, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule